// File: doc/BRIEF.md
# Serial ADC readout controller

This block is the master side of a three-wire link to a serial analog-to-digital converter. The wires are an active-low select, a clock and the converter's data output. A start pulse pulls select low. The block then runs the serial clock and keeps clocking while the data line stays high. The first low level it samples marks the start of the result. After that marker it reads the result twice. The first copy arrives most significant bit first. The second copy repeats the word in the opposite order, and its lowest bit is the one already received last in the first copy. The block compares the two copies, so a corrupted link can be told apart from a converter whose output is simply noisy.

The converter changes its data output on the falling clock edge. The controller therefore takes its sample inside the high phase, one system cycle after the rising edge, when the line is furthest from any transition. The half period is set at run time in system clock cycles. A limit on high samples stops a hunt for a converter that never answers. After each transaction the select and clock return to idle, and a guard interval of one half period follows before a new start is accepted.

Top module: `adc_readout`

## Requirements
- R1: While reset is held and after it is released, cs_no is 1, sclk_o is 0, done_o and timeout_o are 0, and data_o and mismatch_o are 0.
- R2: A start_i pulse while idle drives cs_no low in the next cycle. Whenever cs_no is 1, sclk_o is 0.
- R3: While cs_no is low, sclk_o begins low, and every low phase and every high phase lasts exactly half_div_i system cycles (half_div_i at least 2).
- R4: sdo_i is sampled once per clock period, in the first system cycle of the high phase. Samples that read 1 before the first 0 are discarded, and that first 0 is a marker that is not part of the result.
- R5: The DATA_W samples after the marker form the first copy, bit DATA_W-1 first. data_o presents that first copy.
- R6: done_o is a one-cycle pulse in the same cycle that cs_no rises. data_o and mismatch_o change only in that cycle and hold until the next done_o.
- R7: After the first copy, DATA_W-1 more samples carry bits 1 up to DATA_W-1 of the second copy, lowest first, and bit 0 is shared with the first copy. mismatch_o is 1 exactly when the second copy differs from the first.
- R8: If timeout_i consecutive samples read 1 with no marker, timeout_o pulses for one cycle as cs_no rises, done_o stays 0, and data_o and mismatch_o keep their previous values. timeout_i-1 high samples followed by a 0 still complete normally.
- R9: cs_no rises only in the cycle where sclk_o leaves a complete high phase, so the final high phase is not shortened.
- R10: start_i is ignored while cs_no is low and for half_div_i cycles after cs_no rises. A start pulse in either window starts no new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one readout |
| half_div_i | input | DIV_W | Serial clock half period in system cycles, at least 2 |
| timeout_i | input | TO_W | High samples tolerated before giving up |
| sdo_i | input | 1 | Converter data output, idles high |
| cs_no | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| done_o | output | 1 | One-cycle pulse: result available |
| data_o | output | DATA_W | First (MSB-first) copy of the result |
| mismatch_o | output | 1 | The two copies disagreed |
| timeout_o | output | 1 | One-cycle pulse: no marker seen |

## Verification
The hardest state to reach from the ports is a completed transaction whose two copies disagree only in one bit of the reversed stream. A converter that behaves correctly never produces it. The bench's converter model therefore XORs a chosen mask into the second stream only, with directed masks on the top bit and on bit 1 and random masks elsewhere. The timeout boundary gets the same treatment: the model's run of leading high bits is placed one short of the limit and exactly at it.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_SHIFT,
    ST_CLOSE,
    ST_GUARD
  } seq_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             smp_q;
  logic             wrap;

  assign wrap = (cnt_q == half_div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      smp_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      // strobe lands in the first high cycle, clear of the falling-edge update
      smp_q <= wrap & ~sclk_q;
      if (wrap) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign sample_o = smp_q;
  assign fall_o   = en_i & wrap & sclk_q;

  // R4
  sample_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> sclk_o);

  // R2
  idle_low_after_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_o);
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdo_i,
  input  logic              shift_msb_i,
  input  logic              shift_lsb_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mismatch_o
);
  localparam int REV_W = DATA_W - 1;

  logic [DATA_W-1:0] fwd_q;
  logic [REV_W-1:0]  rev_q;
  logic [DATA_W-1:0] second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= '0;
    else if (shift_msb_i) fwd_q <= {fwd_q[DATA_W-2:0], sdo_i};
  end

  generate
    if (REV_W == 1) begin : g_rev_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rev_q <= '0;
        else if (shift_lsb_i) rev_q <= sdo_i;
      end
    end else begin : g_rev_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rev_q <= '0;
        else if (shift_lsb_i) rev_q <= {sdo_i, rev_q[REV_W-1:1]};
      end
    end
  endgenerate

  // bit 0 is shared between both streams
  assign second = {rev_q, fwd_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      mismatch_o <= 1'b0;
    end else if (load_i) begin
      data_o     <= fwd_q;
      mismatch_o <= (second != fwd_q);
    end
  end

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(data_o) && $stable(mismatch_o)));

  // R7
  shift_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_msb_i && shift_lsb_i));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_readout_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8,
  parameter int TO_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             sdo_i,
  input  logic             sample_i,
  input  logic             fall_i,
  output logic             en_o,
  output logic             cs_no,
  output logic             shift_msb_o,
  output logic             shift_lsb_o,
  output logic             load_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int BIT_W = $clog2(2 * DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(2 * DATA_W - 2);
  localparam logic [BIT_W-1:0] FWD_BITS = BIT_W'(DATA_W);

  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [TO_W-1:0]  hunt_q;
  logic [DIV_W-1:0] guard_q;
  logic             to_q;
  logic             done_q;
  logic             tmo_q;
  logic             hunt_expired;

  assign en_o  = (state_q == ST_HUNT) || (state_q == ST_SHIFT) || (state_q == ST_CLOSE);
  assign cs_no = ~en_o;

  assign shift_msb_o  = (state_q == ST_SHIFT) && sample_i && (bit_q < FWD_BITS);
  assign shift_lsb_o  = (state_q == ST_SHIFT) && sample_i && (bit_q >= FWD_BITS);
  assign load_o       = (state_q == ST_CLOSE) && fall_i && !to_q;
  assign hunt_expired = ({1'b0, hunt_q} + (TO_W+1)'(1)) >= {1'b0, timeout_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      hunt_q  <= '0;
      guard_q <= '0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_HUNT;
            hunt_q  <= '0;
            to_q    <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (sample_i) begin
            if (!sdo_i) begin
              state_q <= ST_SHIFT;
              bit_q   <= '0;
            end else if (hunt_expired) begin
              to_q    <= 1'b1;
              state_q <= ST_CLOSE;
            end else begin
              hunt_q <= hunt_q + TO_W'(1);
            end
          end
        end
        ST_SHIFT: begin
          if (sample_i) begin
            if (bit_q == LAST_BIT) state_q <= ST_CLOSE;
            else bit_q <= bit_q + BIT_W'(1);
          end
        end
        ST_CLOSE: begin
          // release only at the end of a full high phase
          if (fall_i) begin
            state_q <= ST_GUARD;
            guard_q <= '0;
            done_q  <= ~to_q;
            tmo_q   <= to_q;
          end
        end
        ST_GUARD: begin
          if (guard_q == half_div_i - DIV_W'(1)) state_q <= ST_IDLE;
          else guard_q <= guard_q + DIV_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_tmo_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  // R8
  tmo_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cs_no);

  // R10
  guard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
endmodule

// File: rtl/adc_readout.sv
module adc_readout #(
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic              sdo_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mismatch_o,
  output logic              timeout_o
);
  logic en;
  logic sample;
  logic fall;
  logic shift_msb;
  logic shift_lsb;
  logic load;

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .half_div_i (half_div_i),
    .sclk_o     (sclk_o),
    .sample_o   (sample),
    .fall_o     (fall)
  );

  adc_seq_fsm #(.DATA_W(DATA_W), .DIV_W(DIV_W), .TO_W(TO_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .half_div_i  (half_div_i),
    .timeout_i   (timeout_i),
    .sdo_i       (sdo_i),
    .sample_i    (sample),
    .fall_i      (fall),
    .en_o        (en),
    .cs_no       (cs_no),
    .shift_msb_o (shift_msb),
    .shift_lsb_o (shift_lsb),
    .load_o      (load),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  adc_bit_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sdo_i       (sdo_i),
    .shift_msb_i (shift_msb),
    .shift_lsb_i (shift_lsb),
    .load_i      (load),
    .data_o      (data_o),
    .mismatch_o  (mismatch_o)
  );

  // R2
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R9
  release_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(sclk_o));

  // R6
  done_with_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_no));
endmodule

// File: tb/tb_adc_readout.sv
module tb_adc_readout;
  localparam int W  = 12;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sdo = 1'b1;
  logic [DW-1:0] div = DW'(2);
  logic [TW-1:0] tmo = TW'(40);
  logic          cs_no, sclk, done, mism, tmo_o;
  logic [W-1:0]  data;

  always #4 clk = ~clk;

  adc_readout #(.DATA_W(W), .DIV_W(DW), .TO_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .half_div_i(div),
    .timeout_i(tmo), .sdo_i(sdo), .cs_no(cs_no), .sclk_o(sclk),
    .done_o(done), .data_o(data), .mismatch_o(mism), .timeout_o(tmo_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // converter model
  logic [W-1:0] m_val = '0;
  logic [W-1:0] m_cm  = '0;
  int m_pre = 0;
  int k = 0;
  logic sclk_prev = 1'b0;
  logic cs_prev = 1'b1;
  int run = 0;
  int phase_err = 0;

  function automatic logic stream_bit(input int idx);
    int d;
    if (idx < m_pre) return 1'b1;
    if (idx == m_pre) return 1'b0;
    d = idx - m_pre - 1;
    if (d < W) return m_val[W-1-d];
    d = d - W;
    if (d < W - 1) return m_val[d+1] ^ m_cm[d+1];
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (cs_prev && !cs_no) begin
      k = 0;
      sdo = stream_bit(0);
    end else if (!cs_no && sclk_prev && !sclk) begin
      k = k + 1;
      sdo = stream_bit(k);
    end else if (cs_no) begin
      sdo = 1'b1;
    end
    // R3 phase length monitor
    if (!cs_no) begin
      if (cs_prev) run = 1;
      else if (sclk == sclk_prev) run = run + 1;
      else begin
        if (run != int'(div)) phase_err = phase_err + 1;
        run = 1;
      end
    end else if (!cs_prev) begin
      if (run != int'(div)) phase_err = phase_err + 1;
    end
    sclk_prev = sclk;
    cs_prev = cs_no;
  end

  logic [W-1:0] last_data = '0;
  logic         last_mis  = 1'b0;

  task automatic xfer(input logic [W-1:0] val, input int pre, input int d,
                      input logic [W-1:0] cm, input int tlim, input bit poke);
    int n;
    bit expect_to;
    m_val = val;
    m_cm = cm & ~W'(1);
    m_pre = pre;
    div = DW'(d);
    tmo = TW'(tlim);
    phase_err = 0;
    expect_to = (pre >= tlim);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 select low after start", cs_no, 0);
    n = 0;
    while (!done && !tmo_o && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (expect_to) begin
      chk("R8 timeout pulse", tmo_o, 1);
      chk("R8 no done on timeout", done, 0);
      chk("R8 data kept", data, last_data);
      chk("R8 mismatch kept", mism, last_mis);
    end else begin
      chk("R6 done pulse", done, 1);
      chk("R5 data", data, val);
      chk("R7 mismatch", mism, (m_cm != '0));
      last_data = val;
      last_mis = (m_cm != '0);
    end
    chk("R9 select released", cs_no, 1);
    chk("R2 clock idle", sclk, 0);
    chk("R3 phase lengths", phase_err, 0);
    @(negedge clk);
    chk("R6 single cycle", {done, tmo_o}, 2'b00);
    if (poke) begin
      for (int i = 0; i < 3 * d; i++) begin
        if (cs_no !== 1'b1) n = -1;
        @(negedge clk);
      end
      chk("R10 start while busy ignored", n < 0, 0);
    end
    repeat (d + 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int errs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset select", cs_no, 1);
    chk("R1 reset clock", sclk, 0);
    chk("R1 reset flags", {done, tmo_o, mism}, 0);
    chk("R1 reset data", data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {cs_no, sclk, done, tmo_o}, 4'b1000);

    // directed corners
    xfer(12'h000, 0, 2, '0, 40, 0);
    xfer(12'hFFF, 3, 3, '0, 40, 0);
    xfer(12'hA5C, 1, 2, '0, 40, 0);
    xfer(12'h5A3, 2, 4, 12'h800, 40, 0);   // R7 top bit of reversed copy
    xfer(12'h123, 0, 2, 12'h002, 40, 0);   // R7 bit 1
    xfer(12'h777, 9, 2, '0, 10, 0);        // R8 one below limit
    xfer(12'h321, 10, 2, '0, 10, 0);       // R8 exactly at limit
    xfer(12'h0F0, 30, 3, '0, 5, 0);        // R8 far past limit
    xfer(12'h9C6, 2, 3, '0, 40, 1);        // R10 start while busy

    // R10 start inside guard window
    m_val = 12'h456; m_cm = '0; m_pre = 1; div = DW'(4); tmo = TW'(40);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    chk("R5 data before guard", data, 12'h456);
    last_data = 12'h456; last_mis = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    errs = 0;
    for (int i = 0; i < 12; i++) begin
      if (cs_no !== 1'b1) errs++;
      @(negedge clk);
    end
    chk("R10 start in guard ignored", errs, 0);

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [W-1:0] v, cm;
      int pre, d;
      v = W'($urandom);
      pre = $urandom_range(0, 7);
      d = $urandom_range(2, 5);
      cm = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
      xfer(v, pre, d, cm, 40, 0);
    end

    report();
    $finish;
  end
endmodule